// File: doc/BRIEF.md
# Indexed Block Register Slave on a Two-Wire Management Bus

This block answers a two-wire management bus (SMBus) as a slave at 7-bit address 6Eh and serves a small bank of 8-bit control bytes. SCL and SDA are oversampled by the block clock through synchroniser flops. Start and stop conditions are found from SDA edges while SCL is high. SDA is driven open-drain: the block only ever pulls the line low. Every transfer first names a starting offset. A write then gives a byte count and the data bytes. A read turns the bus around with a repeated start, returns a byte count, and then streams bytes from the offset onward.

The bank holds four writable bytes at offsets 0 to 3, a read-only revision/vendor byte at offset 4, and two read-only identification bytes at offsets 62 and 63. The writable bytes drive the clock-output control logic: a power-down drive-mode bit, a stop drive-mode bit, a bandwidth select and a PLL/bypass select (the last two gated by hardware pins), and, for four output pairs, an enable bit and a stoppable bit each.

Top module: `smb_reg_slave`

## Requirements
- R1: The slave acknowledges address byte DCh after any start. It acknowledges DDh only after a repeated start that follows an acknowledged offset byte in the same transfer. Any other address byte is not acknowledged, and the slave then ignores the bus until the next start.
- R2: After reset the bytes read back as: offset 0 = 07h, offset 1 = FFh, offset 2 = 00h, offset 3 = 00h, offset 4 = 05h, offset 62 = 30h, offset 63 = 14h. SDA is released.
- R3: A write is DCh, offset, count N (N ≥ 1), then data bytes. The slave acknowledges each of the first N data bytes and stores them at consecutive offsets from the starting offset. A data byte past the Nth is not acknowledged and is discarded, and the slave then waits for a start.
- R4: A count byte of 00h is not acknowledged. The slave then ignores the bus, including data bytes, until the next start, and no register changes.
- R5: A read is DCh, offset, repeated start, DDh. The slave then sends the byte count READ_LEN (default 5), followed by bytes from consecutive offsets for as long as the master acknowledges. A master not-acknowledge, or a stop after any acknowledged byte, ends the read.
- R6: Data written to offset 4, 62, 63 or any unimplemented offset is acknowledged and has no effect. Reads of unimplemented offsets (5 to 61, 64 and above) return 00h.
- R7: Offset 0 bit 7 drives `pd_drive` and bit 6 drives `stop_drive`. `low_bw` is bit 2 ANDed with `bw_pin`, and `pll_mode` is bit 1 ANDed with `pll_pin`.
- R8: In offset 1, bits 1, 2, 5 and 6 drive `pair_oe[0]`, `pair_oe[1]`, `pair_oe[2]` and `pair_oe[3]`. In offset 2 the same bit positions drive `pair_stop[3:0]`, where 1 means stoppable and 0 means free running.
- R9: The slave changes `sda_drive_low` only while the synchronised SCL is low, and releases SDA after a stop.
- R10: The control outputs other than the pin-gated pair change only in the cycle after an accepted data byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |
| bw_pin | input | 1 | Hardware pin ANDed with the bandwidth bit |
| pll_pin | input | 1 | Hardware pin ANDed with the PLL/bypass bit |
| pd_drive | output | 1 | Power-down drive mode |
| stop_drive | output | 1 | Stop drive mode |
| low_bw | output | 1 | Effective low-bandwidth select |
| pll_mode | output | 1 | Effective PLL (1) or bypass (0) |
| pair_oe | output | 4 | Output enable per pair |
| pair_stop | output | 4 | Stoppable (1) or free running (0) per pair |

## Verification
The checks assume a well-behaved master. SDA changes only while SCL is low, except in start and stop conditions. Every SCL phase lasts well beyond the synchroniser latency. A stop is issued only while the slave has released SDA. The bench master holds each quarter of a bit for eight block clocks and issues stop only after an acknowledge phase it drove itself or after a not-acknowledge. Under those assumptions, an SDA change while SCL is high is a fault of the slave.

// File: rtl/smb_reg_pkg.sv
package smb_reg_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_PAIRS = 4;
    localparam logic [6:0] DEV_ADDR = 7'h6E;

    // bit position of each output pair inside the enable and stop bytes
    localparam logic [NUM_PAIRS-1:0][2:0] PAIR_POS = {3'd6, 3'd5, 3'd2, 3'd1};

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_OFFS,
        ST_OFFS_ACK,
        ST_WCNT,
        ST_WCNT_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_TXB,
        ST_TXB_ACK
    } smb_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic                 pd_drive;
        logic                 stop_drive;
        logic                 bw_low_raw;
        logic                 pll_raw;
        logic [NUM_PAIRS-1:0] oe;
        logic [NUM_PAIRS-1:0] stoppable;
    } ctrl_fields_t;

    function automatic logic [BYTE_W-1:0] rw_reset(input int idx);
        case (idx)
            0:       return 8'h07;
            1:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_reg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_q, sda_q;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smb_reg_pkg::*;
#(
    parameter int               NUM_RW   = 4,
    parameter int               RO_OFFS  = 4,
    parameter int               ID_OFFS  = 62,
    parameter logic [BYTE_W-1:0] RO_VAL   = 8'h05,
    parameter logic [BYTE_W-1:0] ID_A_VAL = 8'h30,
    parameter logic [BYTE_W-1:0] ID_B_VAL = 8'h14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output ctrl_fields_t      fields
);
    localparam logic [BYTE_W-1:0] RO_A   = BYTE_W'(RO_OFFS);
    localparam logic [BYTE_W-1:0] ID_A_A = BYTE_W'(ID_OFFS);
    localparam logic [BYTE_W-1:0] ID_B_A = BYTE_W'(ID_OFFS + 1);

    logic [NUM_RW-1:0][BYTE_W-1:0] rw_q;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_RW; i++) begin
            if (rst) begin
                rw_q[i] <= rw_reset(i);
            end else if (wr_en && wr_addr == BYTE_W'(i)) begin
                rw_q[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_RW; i++) begin
            if (rd_addr == BYTE_W'(i)) rd_data = rw_q[i];
        end
        if (rd_addr == RO_A)   rd_data = RO_VAL;
        if (rd_addr == ID_A_A) rd_data = ID_A_VAL;
        if (rd_addr == ID_B_A) rd_data = ID_B_VAL;
    end

    assign fields.pd_drive   = rw_q[0][7];
    assign fields.stop_drive = rw_q[0][6];
    assign fields.bw_low_raw = rw_q[0][2];
    assign fields.pll_raw    = rw_q[0][1];

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        assign fields.oe[p]        = rw_q[1][PAIR_POS[p]];
        assign fields.stoppable[p] = rw_q[2][PAIR_POS[p]];
    end
endmodule

// File: rtl/smb_ctrl_gate.sv
module smb_ctrl_gate
    import smb_reg_pkg::*;
(
    input  ctrl_fields_t         fields,
    input  logic                 bw_pin,
    input  logic                 pll_pin,
    output logic                 pd_drive,
    output logic                 stop_drive,
    output logic                 low_bw,
    output logic                 pll_mode,
    output logic [NUM_PAIRS-1:0] pair_oe,
    output logic [NUM_PAIRS-1:0] pair_stop
);
    always_comb begin
        pd_drive   = fields.pd_drive;
        stop_drive = fields.stop_drive;
        low_bw     = fields.bw_low_raw & bw_pin;
        pll_mode   = fields.pll_raw & pll_pin;
        pair_oe    = fields.oe;
        pair_stop  = fields.stoppable;
    end
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
    import smb_reg_pkg::*;
#(
    parameter int               READ_LEN    = 5,
    parameter int               SYNC_STAGES = 2,
    parameter int               NUM_RW      = 4,
    parameter int               RO_OFFS     = 4,
    parameter int               ID_OFFS     = 62,
    parameter logic [BYTE_W-1:0] RO_VAL      = 8'h05,
    parameter logic [BYTE_W-1:0] ID_A_VAL    = 8'h30,
    parameter logic [BYTE_W-1:0] ID_B_VAL    = 8'h14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_in,
    input  logic                 sda_in,
    output logic                 sda_drive_low,
    input  logic                 bw_pin,
    input  logic                 pll_pin,
    output logic                 pd_drive,
    output logic                 stop_drive,
    output logic                 low_bw,
    output logic                 pll_mode,
    output logic [NUM_PAIRS-1:0] pair_oe,
    output logic [NUM_PAIRS-1:0] pair_stop
);
    localparam logic [BYTE_W-1:0] RD_CNT   = BYTE_W'(READ_LEN);
    localparam logic [BYTE_W-1:0] ADDR_WR  = {DEV_ADDR, 1'b0};
    localparam logic [BYTE_W-1:0] ADDR_RD  = {DEV_ADDR, 1'b1};
    localparam logic [3:0]        BIT_DONE = 4'd8;

    bus_ev_t           ev;
    ctrl_fields_t      fields;
    smb_state_e        state;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg, offs_q, rem_q, rd_data;
    logic              offs_valid, is_read, mack, sda_low;
    logic              wr_en, byte_in, scl_s, stop_s;

    smb_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    assign scl_s   = ev.scl;
    assign stop_s  = ev.stop;
    assign byte_in = ev.scl_fall && (bitcnt == BIT_DONE);
    assign wr_en   = (state == ST_WDAT) && byte_in && (rem_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            offs_q     <= '0;
            rem_q      <= '0;
            offs_valid <= 1'b0;
            is_read    <= 1'b0;
            mack       <= 1'b0;
            sda_low    <= 1'b0;
        end else if (ev.stop) begin
            state      <= ST_IDLE;
            sda_low    <= 1'b0;
            offs_valid <= 1'b0;
        end else if (ev.start) begin
            state   <= ST_ADDR;
            bitcnt  <= '0;
            sda_low <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_OFFS, ST_WCNT, ST_WDAT: begin
                    if (ev.scl_rise && bitcnt != BIT_DONE) begin
                        shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_in) begin
                        bitcnt <= '0;
                        case (state)
                            ST_ADDR: begin
                                if (shreg == ADDR_WR) begin
                                    state   <= ST_ADDR_ACK;
                                    is_read <= 1'b0;
                                    sda_low <= 1'b1;
                                end else if (shreg == ADDR_RD && offs_valid) begin
                                    state   <= ST_ADDR_ACK;
                                    is_read <= 1'b1;
                                    sda_low <= 1'b1;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            ST_OFFS: begin
                                offs_q     <= shreg;
                                offs_valid <= 1'b1;
                                state      <= ST_OFFS_ACK;
                                sda_low    <= 1'b1;
                            end
                            ST_WCNT: begin
                                if (shreg == '0) begin
                                    state <= ST_IDLE;
                                end else begin
                                    rem_q   <= shreg;
                                    state   <= ST_WCNT_ACK;
                                    sda_low <= 1'b1;
                                end
                            end
                            default: begin
                                if (rem_q != '0) begin
                                    offs_q  <= offs_q + 8'd1;
                                    rem_q   <= rem_q - 8'd1;
                                    state   <= ST_WDAT_ACK;
                                    sda_low <= 1'b1;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                        endcase
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev.scl_fall) begin
                        if (is_read) begin
                            state   <= ST_TXB;
                            shreg   <= RD_CNT;
                            sda_low <= ~RD_CNT[BYTE_W-1];
                            bitcnt  <= '0;
                        end else begin
                            state   <= ST_OFFS;
                            sda_low <= 1'b0;
                        end
                    end
                end
                ST_OFFS_ACK: begin
                    if (ev.scl_fall) begin
                        state   <= ST_WCNT;
                        sda_low <= 1'b0;
                    end
                end
                ST_WCNT_ACK, ST_WDAT_ACK: begin
                    if (ev.scl_fall) begin
                        state   <= ST_WDAT;
                        sda_low <= 1'b0;
                    end
                end
                ST_TXB: begin
                    if (ev.scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            sda_low <= 1'b0;
                            state   <= ST_TXB_ACK;
                        end else begin
                            shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_low <= ~shreg[BYTE_W-2];
                            bitcnt  <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_TXB_ACK: begin
                    if (ev.scl_rise) begin
                        mack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (mack) begin
                            shreg   <= rd_data;
                            sda_low <= ~rd_data[BYTE_W-1];
                            offs_q  <= offs_q + 8'd1;
                            bitcnt  <= '0;
                            state   <= ST_TXB;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_drive_low = sda_low;

    smb_reg_bank #(
        .NUM_RW   (NUM_RW),
        .RO_OFFS  (RO_OFFS),
        .ID_OFFS  (ID_OFFS),
        .RO_VAL   (RO_VAL),
        .ID_A_VAL (ID_A_VAL),
        .ID_B_VAL (ID_B_VAL)
    ) i_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (offs_q),
        .wr_data (shreg),
        .rd_addr (offs_q),
        .rd_data (rd_data),
        .fields  (fields)
    );

    smb_ctrl_gate i_gate (
        .fields     (fields),
        .bw_pin     (bw_pin),
        .pll_pin    (pll_pin),
        .pd_drive   (pd_drive),
        .stop_drive (stop_drive),
        .low_bw     (low_bw),
        .pll_mode   (pll_mode),
        .pair_oe    (pair_oe),
        .pair_stop  (pair_stop)
    );
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk
    import smb_reg_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 scl_s,
    input logic                 stop_s,
    input logic                 sda_drive_low,
    input logic                 wr_en,
    input smb_state_e           state,
    input logic                 pd_drive,
    input logic                 stop_drive,
    input logic [NUM_PAIRS-1:0] pair_oe,
    input logic [NUM_PAIRS-1:0] pair_stop
);
    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_drive_low) |-> !scl_s) else $error("sda changed with scl high"); // R9

    AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        stop_s |=> !sda_drive_low) else $error("sda held after stop"); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_drive_low) else $error("idle slave drives sda"); // R1

    AST_RESET_FIELDS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pair_oe == '1 && pair_stop == '0 && !pd_drive && !stop_drive))
        else $error("fields wrong after reset"); // R2

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> ($stable(pair_oe) && $stable(pair_stop)
                           && $stable(pd_drive) && $stable(stop_drive)))
        else $error("fields moved without a write"); // R10
endmodule

bind smb_reg_slave smb_reg_slave_chk i_chk (
    .clk           (clk),
    .rst           (rst),
    .scl_s         (scl_s),
    .stop_s        (stop_s),
    .sda_drive_low (sda_drive_low),
    .wr_en         (wr_en),
    .state         (state),
    .pd_drive      (pd_drive),
    .stop_drive    (stop_drive),
    .pair_oe       (pair_oe),
    .pair_stop     (pair_stop)
);

// File: tb/test_smb_reg_slave.sv
module test_smb_reg_slave;
    localparam int Q  = 8;
    localparam int RL = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       pin_bw = 1'b1, pin_pll = 1'b1;
    logic       sda_drive_low, sda_bus;
    logic       pd_drive, stop_drive, low_bw, pll_mode;
    logic [3:0] pair_oe, pair_stop;

    int   n_chk = 0, n_fail = 0;
    bit   cmp_en = 1'b0, done = 1'b0;
    logic [7:0] mdl [0:255];
    logic [7:0] wbuf [0:7];

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_drive_low;

    smb_reg_slave i_smb_reg_slave (
        .clk           (clk),
        .rst           (rst),
        .scl_in        (scl_m),
        .sda_in        (sda_bus),
        .sda_drive_low (sda_drive_low),
        .bw_pin        (pin_bw),
        .pll_pin       (pin_pll),
        .pd_drive      (pd_drive),
        .stop_drive    (stop_drive),
        .low_bw        (low_bw),
        .pll_mode      (pll_mode),
        .pair_oe       (pair_oe),
        .pair_stop     (pair_stop)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        return mdl[a];
    endfunction

    // per-clock reference comparison of the control fields
    logic prev_sda_low = 1'b0;
    always begin
        @(posedge clk);
        #5;
        if (cmp_en) begin
            chk(pd_drive == mdl[0][7], "R7 pd_drive", pd_drive, mdl[0][7]);
            chk(stop_drive == mdl[0][6], "R7 stop_drive", stop_drive, mdl[0][6]);
            chk(low_bw == (mdl[0][2] & pin_bw), "R7 low_bw", low_bw, mdl[0][2] & pin_bw);
            chk(pll_mode == (mdl[0][1] & pin_pll), "R7 pll_mode", pll_mode, mdl[0][1] & pin_pll);
            chk(pair_oe == {mdl[1][6], mdl[1][5], mdl[1][2], mdl[1][1]}, "R8 R10 pair_oe",
                pair_oe, {mdl[1][6], mdl[1][5], mdl[1][2], mdl[1][1]});
            chk(pair_stop == {mdl[2][6], mdl[2][5], mdl[2][2], mdl[2][1]}, "R8 R10 pair_stop",
                pair_stop, {mdl[2][6], mdl[2][5], mdl[2][2], mdl[2][1]});
        end
        if (!rst && sda_drive_low != prev_sda_low)
            chk(scl_m == 1'b0, "R9 sda moved while scl high", scl_m, 0);
        prev_sda_low = sda_drive_low;
    end

    task automatic wait_q;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wait_q;
        scl_m = 1'b1; wait_q;
        sda_m = 1'b0; wait_q;
        scl_m = 1'b0; wait_q;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wait_q;
        scl_m = 1'b1; wait_q;
        sda_m = 1'b1; wait_q;
        repeat (4) @(negedge clk);
        chk(sda_drive_low == 1'b0, "R9 released after stop", sda_drive_low, 0);
    endtask

    task automatic write_bit(input logic b);
        sda_m = b; wait_q;
        scl_m = 1'b1; wait_q; wait_q;
        scl_m = 1'b0; wait_q;
    endtask

    task automatic read_bit(output logic b);
        sda_m = 1'b1; wait_q;
        scl_m = 1'b1; wait_q;
        b = sda_bus; wait_q;
        scl_m = 1'b0; wait_q;
    endtask

    task automatic send_byte(input logic [7:0] d, output bit acked);
        logic b;
        for (int i = 7; i >= 0; i--) write_bit(d[i]);
        read_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            read_bit(b);
            d[i] = b;
        end
        write_bit(!give_ack);
    endtask

    task automatic do_write(input logic [7:0] offs, input logic [7:0] cnt, input int n);
        bit ak;
        cmp_en = 1'b0;
        bus_start;
        send_byte(8'hDC, ak);
        chk(ak, "R1 write address ack", ak, 1);
        send_byte(offs, ak);
        chk(ak, "R3 offset ack", ak, 1);
        send_byte(cnt, ak);
        chk(ak == (cnt != 0), "R3 R4 count ack", ak, cnt != 0);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ak);
            chk(ak == (cnt != 0 && i < int'(cnt)), "R3 R4 data ack", ak, cnt != 0 && i < int'(cnt));
            if (cnt != 0 && i < int'(cnt) && (offs + 8'(i)) < 8'd4) mdl[offs + 8'(i)] = wbuf[i];
        end
        bus_stop;
        cmp_en = 1'b1;
    endtask

    task automatic do_read(input logic [7:0] offs, input int n, input string req);
        bit ak;
        logic [7:0] d;
        cmp_en = 1'b0;
        bus_start;
        send_byte(8'hDC, ak);
        chk(ak, "R1 address ack", ak, 1);
        send_byte(offs, ak);
        chk(ak, "R5 offset ack", ak, 1);
        bus_start;
        send_byte(8'hDD, ak);
        chk(ak, "R1 read address ack after offset", ak, 1);
        recv_byte(n > 0, d);
        chk(d == 8'(RL), "R5 byte count", d, RL);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            chk(d == exp_rd(offs + 8'(i)), req, d, exp_rd(offs + 8'(i)));
        end
        bus_stop;
        cmp_en = 1'b1;
    endtask

    initial begin
        bit ak;
        for (int a = 0; a < 256; a++) mdl[a] = 8'h00;
        mdl[0] = 8'h07; mdl[1] = 8'hFF; mdl[4] = 8'h05; mdl[62] = 8'h30; mdl[63] = 8'h14;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state at the ports
        chk(sda_drive_low == 1'b0, "R2 sda released", sda_drive_low, 0);
        chk(pair_oe == 4'hF, "R2 pair_oe", pair_oe, 4'hF);
        chk(pair_stop == 4'h0, "R2 pair_stop", pair_stop, 0);
        chk({pd_drive, stop_drive, low_bw, pll_mode} == 4'b0011, "R2 byte0 fields",
            {pd_drive, stop_drive, low_bw, pll_mode}, 4'b0011);
        cmp_en = 1'b1;
        repeat (10) @(negedge clk);

        do_read(8'd0, 5, "R2 R5 reset readback");

        wbuf[0] = 8'hC0; wbuf[1] = 8'h22; wbuf[2] = 8'h44;
        do_write(8'd0, 8'd3, 3);                      // R3 R7 R8
        do_read(8'd0, 3, "R3 readback");

        wbuf[0] = 8'h06;
        do_write(8'd0, 8'd1, 1);                      // R7 pin gating next
        for (int k = 0; k < 4; k++) begin
            pin_bw = k[0]; pin_pll = k[1];
            repeat (20) @(negedge clk);
        end
        pin_bw = 1'b1; pin_pll = 1'b1;

        wbuf[0] = 8'h0F; wbuf[1] = 8'hAA;
        do_write(8'd1, 8'd1, 2);                      // R3 byte past count nacked
        do_read(8'd1, 2, "R3 extra byte discarded");

        wbuf[0] = 8'h66; wbuf[1] = 8'h5A; wbuf[2] = 8'h99;
        do_write(8'd2, 8'd3, 3);                      // R6 offset 4 ignored
        do_read(8'd2, 3, "R6 read-only byte kept");

        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        do_write(8'd62, 8'd2, 2);                     // R6 id bytes ignored
        do_read(8'd62, 3, "R6 id and unimplemented");

        wbuf[0] = 8'h00;
        do_write(8'd1, 8'd0, 1);                      // R4 zero count
        do_read(8'd1, 1, "R4 register unchanged");

        cmp_en = 1'b0;
        bus_start;                                    // R1 foreign address
        send_byte(8'hA0, ak);
        chk(!ak, "R1 foreign address nack", ak, 0);
        send_byte(8'hDC, ak);
        chk(!ak, "R1 bus ignored after foreign address", ak, 0);
        bus_stop;
        bus_start;                                    // R1 read address without offset
        send_byte(8'hDD, ak);
        chk(!ak, "R1 DDh without offset nack", ak, 0);
        bus_stop;
        cmp_en = 1'b1;

        do_read(8'd0, 2, "R5 early end of read");
        do_read(8'd5, 2, "R6 unimplemented reads zero");
        repeat (20) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule